// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block produces the clock fed to a smart card contact from a faster reference clock. A two-bit select picks one of four divide ratios. The select may be changed while the output runs. The new ratio is adopted only at the boundary between a completed low phase and the next high phase, so the output never carries a shortened pulse. A run/hold gate from the activation sequencer parks the output low and restarts it. Parking waits for the high phase in progress to finish, and a restart always begins with a full-width high phase.

The block runs on a reference clock at twice the crystal rate. Each output level therefore lasts L reference cycles, and the output period of 2L cycles equals the divide ratio times one crystal period. The select is assumed to come from another timing domain, so it passes through two synchronizing stages. A synchronous active-low reset loads the ratio straight from the select pins.

Top module: `card_clk_div`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, card_clk is low. The first high phase after reset uses the ratio on ratio_sel during reset.
- R2: The level length L in reference cycles is set by ratio_sel as follows: 2'b00 gives L=8, 2'b01 gives L=4, 2'b11 gives L=2, and 2'b10 gives L=1.
- R3: While run is high and the select is steady, every high phase and every low phase lasts exactly L cycles.
- R4: A new ratio is adopted only where a high phase begins after a completed low phase. The last pulse at the old ratio and the first pulse at the new ratio both have full width.
- R5: After a select change, a high phase with the new width begins within 2*Lold+2 cycles, where Lold is the level length before the change.
- R6: Every high phase lasts exactly 1, 2, 4 or 8 cycles. Every low phase lasts at least as long as the high phase before it.
- R7: When run goes low, a high phase in progress runs to its full width, and card_clk then stays low for as long as run is low.
- R8: When run returns high while the output is parked, card_clk rises on the next clock edge. That high phase has full width at the ratio currently selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the crystal rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 2 | Divide-ratio select, one bit changed at a time |
| run | input | 1 | High lets the output toggle, low parks it low |
| card_clk | output | 1 | Divided card clock |

## Verification
The output is registered, so a change on run shows on card_clk at the next rising edge. A new select value needs two synchronizer cycles and then waits for the end of the current old-ratio low phase, which gives the 2*Lold+2 bound. The bench drives inputs and samples card_clk on falling edges. It counts the cycle of every rising edge from the cycle in which an input changed. For each select change, it walks the pulses until one with the new width appears, then compares that rise cycle with the bound. A monitor measures every completed level against the width rules.

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       run,
  output logic       card_clk
);
  localparam logic [CNT_W-1:0] PARKED = '1;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [1:0]       sel_m, sel_s;
  logic [CNT_W-1:0] cnt, len;
  logic             phase_end;

  function automatic logic [CNT_W-1:0] level_len(input logic [1:0] s);
    case (s)
      2'b00:   level_len = CNT_W'(8);
      2'b01:   level_len = CNT_W'(4);
      2'b11:   level_len = CNT_W'(2);
      default: level_len = CNT_W'(1);
    endcase
  endfunction

  assign phase_end = (cnt >= len - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_m    <= ratio_sel;
      sel_s    <= ratio_sel;
      len      <= level_len(ratio_sel);
      cnt      <= PARKED;
      card_clk <= 1'b0;
    end else begin
      sel_m <= ratio_sel;
      sel_s <= sel_m;
      if (card_clk) begin
        if (phase_end) begin
          card_clk <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (phase_end) begin
        len <= level_len(sel_s);
        if (run) begin
          card_clk <= 1'b1;
          cnt      <= '0;
        end else begin
          cnt <= PARKED;
        end
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic card_clk
);
  logic [4:0] hi_cnt, lo_cnt, last_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      last_hi <= '0;
    end else if (card_clk) begin
      hi_cnt <= hi_cnt + 5'd1;
      lo_cnt <= '0;
    end else begin
      if (hi_cnt != 5'd0) last_hi <= hi_cnt;
      hi_cnt <= '0;
      lo_cnt <= (lo_cnt == 5'd31) ? lo_cnt : lo_cnt + 5'd1;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !card_clk);

  p_width_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> (hi_cnt == 5'd1 || hi_cnt == 5'd2 || hi_cnt == 5'd4 || hi_cnt == 5'd8));

  p_low_not_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |-> (lo_cnt >= last_hi));

  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_clk && !run) |=> !card_clk);

  p_rise_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |-> $past(run));
endmodule

bind card_clk_div card_clk_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .card_clk(card_clk)
);

// File: tb/card_clk_div_bench.sv
module card_clk_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic       run = 1'b1;
  logic       card_clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic done = 1'b0;

  card_clk_div u_card_clk_div (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .run(run), .card_clk(card_clk)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {select, expected level length}; consecutive selects differ in one bit
  localparam logic [5:0] VEC [8] = '{
    {2'b01, 4'd4}, {2'b11, 4'd2}, {2'b10, 4'd1}, {2'b00, 4'd8},
    {2'b10, 4'd1}, {2'b11, 4'd2}, {2'b01, 4'd4}, {2'b00, 4'd8}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_rise(output int at);
    logic p;
    bit found;
    p = card_clk;
    found = 1'b0;
    while (!found) begin
      @(negedge clk);
      if (card_clk && !p) found = 1'b1;
      p = card_clk;
    end
    at = cyc;
  endtask

  task automatic width_of(input logic v, output int w);
    bit same;
    w = 1;
    same = 1'b1;
    while (same) begin
      @(negedge clk);
      if (card_clk == v) w++;
      else same = 1'b0;
    end
  endtask

  // monitor of completed levels (R6)
  logic mon_prev = 1'b0;
  bit   mon_arm = 1'b0;
  int   mon_w = 0;
  int   mon_last_hi = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_arm = 1'b0;
      mon_prev = card_clk;
      mon_w = 0;
    end else begin
      if (card_clk != mon_prev) begin
        if (mon_arm && mon_prev)
          check(mon_w == 1 || mon_w == 2 || mon_w == 4 || mon_w == 8, "R6 high width", mon_w, 8);
        if (mon_arm && !mon_prev)
          check(mon_w >= mon_last_hi, "R6 low after high", mon_w, mon_last_hi);
        if (mon_prev) mon_last_hi = mon_w;
        if (card_clk) mon_arm = 1'b1;
        mon_w = 1;
      end else begin
        mon_w++;
      end
      mon_prev = card_clk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int at, w, c0, lprev;
    bit ok;
    repeat (5) @(negedge clk);
    check(card_clk == 1'b0, "R1 low in reset", card_clk, 0);
    rst_n = 1'b1;
    c0 = cyc;
    next_rise(at);
    check(at == c0 + 1, "R1 first rise cycle", at - c0, 1);
    width_of(1'b1, w);
    check(w == 8, "R1 first high width", w, 8);

    lprev = 8;
    for (int i = 0; i < 8; i++) begin
      int lnew;
      lnew = int'(VEC[i][3:0]);
      ratio_sel = VEC[i][5:4];
      c0 = cyc;
      ok = 1'b0;
      while (!ok) begin
        next_rise(at);
        width_of(1'b1, w);
        if (w == lnew) ok = 1'b1;
      end
      check(at - c0 <= 2 * lprev + 2, "R5 adoption latency", at - c0, 2 * lprev + 2);
      check(w == lnew, "R4 first new pulse full width", w, lnew);
      width_of(1'b0, w);
      check(w == lnew, "R3 low phase width", w, lnew);
      width_of(1'b1, w);
      check(w == lnew, "R2 ratio encoding high width", w, lnew);
      lprev = lnew;
    end

    // hold during a high phase at L=8
    next_rise(at);
    run = 1'b0;
    width_of(1'b1, w);
    check(w == 8, "R7 high finishes before hold", w, 8);
    ok = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (card_clk) ok = 1'b0;
    end
    check(ok, "R7 output parked low", card_clk, 0);
    ratio_sel = 2'b10;
    repeat (5) @(negedge clk);
    check(card_clk == 1'b0, "R7 still parked after select change", card_clk, 0);
    run = 1'b1;
    c0 = cyc;
    next_rise(at);
    check(at == c0 + 1, "R8 restart on next edge", at - c0, 1);
    width_of(1'b1, w);
    check(w == 1, "R8 restart uses current ratio", w, 1);

    // hold while low, restart at L=2
    ratio_sel = 2'b11;
    repeat (6) @(negedge clk);
    run = 1'b0;
    repeat (20) @(negedge clk);
    check(card_clk == 1'b0, "R7 parked after hold in low", card_clk, 0);
    run = 1'b1;
    c0 = cyc;
    next_rise(at);
    check(at == c0 + 1, "R8 second restart edge", at - c0, 1);
    width_of(1'b1, w);
    check(w == 2, "R8 second restart width", w, 2);

    // reset mid-run takes the ratio from the select
    ratio_sel = 2'b01;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(card_clk == 1'b0, "R1 low in second reset", card_clk, 0);
    rst_n = 1'b1;
    next_rise(at);
    width_of(1'b1, w);
    check(w == 4, "R1 ratio loaded in reset", w, 4);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule